// File: doc/BRIEF.md
# Caption Line Data Serializer

This block places closed-caption data into the vertical-blanking interval of a 525-line or 625-line video stream. Each field has its own pair of caption bytes. When a line begins, the block decides from the line number, the field identifier and the standard select whether this line carries caption data. On a caption line it takes a snapshot of that field's two bytes and of the bit period. It then emits a framed serial burst, timed in pixel clocks, starting at a fixed pixel position.

The burst has three parts. First comes a clock run-in of square cycles, one cycle per bit period. Then come three start bits. Last come the sixteen data bits, with the first byte before the second and each byte least-significant bit first. The block drives a one-bit data level and a valid flag. A downstream stage turns these into luma. On all other lines both outputs stay low.

Top module: `cc_line_serializer`

## Requirements
- R1: While reset is asserted, and right after it is released, `cc_valid` and `cc_level` are both 0.
- R2: With `field2` = 0, a burst is sent only on line 21 when `std_625` = 0, and only on line 22 when `std_625` = 1.
- R3: With `field2` = 1, a burst is sent only on line 284 when `std_625` = 0, and only on line 335 when `std_625` = 1.
- R4: On a line that does not match R2 or R3, `cc_valid` stays 0 and `cc_level` stays 0 for the whole line. Whenever `cc_valid` is 0, `cc_level` is 0.
- R5: Take the rising edge that samples `pix_cnt` == START_PIX on a caption line. The first high cycle of `cc_valid` is the cycle after the next rising edge. `cc_valid` then stays high for exactly 26 bit periods.
- R6: Bit slots 0 to 6 are run-in. In each of them `cc_level` is 1 for the first floor(P/2) clocks of the slot and 0 for the rest, where P is the bit period in clocks.
- R7: Slots 7 and 8 carry level 0. Slot 9 carries level 1.
- R8: Slots 10 to 17 carry the field's first byte and slots 18 to 25 its second byte, bit 0 first in each.
- R9: A bit slot lasts `bit_clks` clocks. A `bit_clks` value of 0 selects BIT_CLKS_DEF, which defaults to 27.
- R10: The byte pair and the bit period are captured on the `line_start` strobe. Changing them later on the same line does not alter that line's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | LINE_W | Line number of the line now starting |
| field2 | input | 1 | 0 = first field, 1 = second field |
| std_625 | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| pix_cnt | input | PIX_W | Pixel position within the current line |
| bit_clks | input | PER_W | Bit period in pixel clocks; 0 selects the default |
| f1_byte_a | input | BYTE_W | First caption byte of field 1 |
| f1_byte_b | input | BYTE_W | Second caption byte of field 1 |
| f2_byte_a | input | BYTE_W | First caption byte of field 2 |
| f2_byte_b | input | BYTE_W | Second caption byte of field 2 |
| cc_level | output | 1 | Serial caption data level |
| cc_valid | output | 1 | High while a caption burst is being sent |

## Verification
The bench builds the block with START_PIX lowered to 16 and every other parameter at its default. This keeps the registered output variant and the 27-clock default period. With the short start position, each line's burst fits into a few hundred cycles. The bench can then compare every clock of every burst against the expected waveform, for periods of 2, 4, 5 and 7 clocks as well as the default, including the odd periods whose run-in half-cycle rounds down. It drives the other field's byte registers with complementary values, so selecting the wrong field or the wrong line shows up directly on the data slots.

// File: rtl/cc_ser_pkg.sv
package cc_ser_pkg;

   localparam int F1_LINE_525 = 21;
   localparam int F1_LINE_625 = 22;
   localparam int F2_LINE_525 = 284;
   localparam int F2_LINE_625 = 335;
   localparam int START_BITS  = 3;

   function automatic logic is_caption_line(input logic [31:0] ln,
                                            input logic        fld2,
                                            input logic        s625);
      logic [31:0] want;
      if (!fld2) want = s625 ? F1_LINE_625 : F1_LINE_525;
      else       want = s625 ? F2_LINE_625 : F2_LINE_525;
      return ln == want;
   endfunction

endpackage

// File: rtl/cc_line_gate.sv
module cc_line_gate #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field2,
   input  logic              std_625,
   input  logic              fire,
   output logic              armed
);
   import cc_ser_pkg::*;

   logic hit;

   always_comb hit = is_caption_line({{(32-LINE_W){1'b0}}, line_num}, field2, std_625);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed <= 1'b0;
      else if (line_start) armed <= hit;
      else if (fire)       armed <= 1'b0;
   end
endmodule

// File: rtl/cc_frame_latch.sv
module cc_frame_latch #(
   parameter int BYTE_W       = 8,
   parameter int PER_W        = 8,
   parameter int BIT_CLKS_DEF = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              field2,
   input  logic [PER_W-1:0]  bit_clks,
   input  logic [BYTE_W-1:0] f1_byte_a,
   input  logic [BYTE_W-1:0] f1_byte_b,
   input  logic [BYTE_W-1:0] f2_byte_a,
   input  logic [BYTE_W-1:0] f2_byte_b,
   input  logic              shift_en,
   output logic              data_bit,
   output logic [PER_W-1:0]  period
);
   localparam int PAIR_W = 2 * BYTE_W;
   localparam logic [PER_W-1:0] DEF_P = PER_W'(BIT_CLKS_DEF);

   logic [PAIR_W-1:0] shreg;
   logic [PAIR_W-1:0] pick;

   always_comb pick = field2 ? {f2_byte_b, f2_byte_a} : {f1_byte_b, f1_byte_a};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         period <= DEF_P;
      end else if (line_start) begin
         shreg  <= pick;
         period <= (bit_clks == '0) ? DEF_P : bit_clks;
      end else if (shift_en) begin
         shreg  <= {1'b0, shreg[PAIR_W-1:1]};
      end
   end

   assign data_bit = shreg[0];
endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
   parameter int PER_W     = 8,
   parameter int PIX_W     = 11,
   parameter int NSLOT     = 26,
   parameter int SLOT_W    = 5,
   parameter int START_PIX = 120
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              armed,
   input  logic [PIX_W-1:0]  pix_cnt,
   input  logic [PER_W-1:0]  period,
   output logic              fire,
   output logic              sending,
   output logic              bit_end,
   output logic [SLOT_W-1:0] slot,
   output logic [PER_W-1:0]  cnt
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);
   localparam logic [PIX_W-1:0]  SPIX = PIX_W'(START_PIX);

   assign fire    = armed && !sending && (pix_cnt == SPIX);
   assign bit_end = sending && (cnt == period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sending <= 1'b0;
         slot    <= '0;
         cnt     <= '0;
      end else if (line_start) begin
         sending <= 1'b0;
         slot    <= '0;
         cnt     <= '0;
      end else if (fire) begin
         sending <= 1'b1;
         slot    <= '0;
         cnt     <= '0;
      end else if (bit_end) begin
         cnt <= '0;
         if (slot == LAST) begin
            sending <= 1'b0;
            slot    <= '0;
         end else begin
            slot <= slot + 1'b1;
         end
      end else if (sending) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cc_level_gen.sv
module cc_level_gen #(
   parameter int PER_W     = 8,
   parameter int SLOT_W    = 5,
   parameter int RUNIN_CYC = 7,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sending,
   input  logic [SLOT_W-1:0] slot,
   input  logic [PER_W-1:0]  cnt,
   input  logic [PER_W-1:0]  period,
   input  logic              data_bit,
   output logic              cc_level,
   output logic              cc_valid
);
   localparam logic [SLOT_W-1:0] S_ZERO_END = SLOT_W'(RUNIN_CYC + 2);
   localparam logic [SLOT_W-1:0] S_ONE      = SLOT_W'(RUNIN_CYC + 2);
   localparam logic [SLOT_W-1:0] S_RUN_END  = SLOT_W'(RUNIN_CYC);

   logic lvl_c;

   always_comb begin
      lvl_c = 1'b0;
      if (sending) begin
         if (slot < S_RUN_END)       lvl_c = (cnt < (period >> 1));
         else if (slot < S_ZERO_END) lvl_c = 1'b0;
         else if (slot == S_ONE)     lvl_c = 1'b1;
         else                        lvl_c = data_bit;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cc_level <= 1'b0;
               cc_valid <= 1'b0;
            end else begin
               cc_level <= lvl_c;
               cc_valid <= sending;
            end
         end
      end else begin : g_comb
         assign cc_level = lvl_c;
         assign cc_valid = sending;
      end
   endgenerate
endmodule

// File: rtl/cc_line_serializer.sv
module cc_line_serializer #(
   parameter int LINE_W       = 10,
   parameter int PIX_W        = 11,
   parameter int PER_W        = 8,
   parameter int BYTE_W       = 8,
   parameter int RUNIN_CYC    = 7,
   parameter int BIT_CLKS_DEF = 27,
   parameter int START_PIX    = 120,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field2,
   input  logic              std_625,
   input  logic [PIX_W-1:0]  pix_cnt,
   input  logic [PER_W-1:0]  bit_clks,
   input  logic [BYTE_W-1:0] f1_byte_a,
   input  logic [BYTE_W-1:0] f1_byte_b,
   input  logic [BYTE_W-1:0] f2_byte_a,
   input  logic [BYTE_W-1:0] f2_byte_b,
   output logic              cc_level,
   output logic              cc_valid
);
   localparam int NSLOT     = RUNIN_CYC + cc_ser_pkg::START_BITS + 2 * BYTE_W;
   localparam int SLOT_W    = $clog2(NSLOT);
   localparam int DATA_SLOT = RUNIN_CYC + cc_ser_pkg::START_BITS;

   generate
      if (LINE_W < 9 || LINE_W > 31)
         $error("LINE_W must hold line 335");
      if (BIT_CLKS_DEF < 2 || BIT_CLKS_DEF >= (1 << PER_W))
         $error("BIT_CLKS_DEF out of range for PER_W");
      if (START_PIX < 0 || START_PIX >= (1 << PIX_W))
         $error("START_PIX out of range for PIX_W");
      if (RUNIN_CYC < 1)
         $error("RUNIN_CYC must be positive");
   endgenerate

   logic              armed, fire, sending, bit_end, data_bit, shift_en;
   logic [SLOT_W-1:0] slot;
   logic [PER_W-1:0]  cnt, period;

   assign shift_en = bit_end && (slot >= SLOT_W'(DATA_SLOT));

   cc_line_gate #(.LINE_W(LINE_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
      .field2(field2), .std_625(std_625), .fire(fire), .armed(armed));

   cc_frame_latch #(.BYTE_W(BYTE_W), .PER_W(PER_W), .BIT_CLKS_DEF(BIT_CLKS_DEF)) u_latch (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .field2(field2),
      .bit_clks(bit_clks), .f1_byte_a(f1_byte_a), .f1_byte_b(f1_byte_b),
      .f2_byte_a(f2_byte_a), .f2_byte_b(f2_byte_b), .shift_en(shift_en),
      .data_bit(data_bit), .period(period));

   cc_bit_timer #(.PER_W(PER_W), .PIX_W(PIX_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W),
                  .START_PIX(START_PIX)) u_timer (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .armed(armed),
      .pix_cnt(pix_cnt), .period(period), .fire(fire), .sending(sending),
      .bit_end(bit_end), .slot(slot), .cnt(cnt));

   cc_level_gen #(.PER_W(PER_W), .SLOT_W(SLOT_W), .RUNIN_CYC(RUNIN_CYC),
                  .OUT_REG(OUT_REG)) u_level (
      .clk(clk), .rst_n(rst_n), .sending(sending), .slot(slot), .cnt(cnt),
      .period(period), .data_bit(data_bit), .cc_level(cc_level), .cc_valid(cc_valid));
endmodule

// File: rtl/cc_line_serializer_chk.sv
module cc_line_serializer_chk #(
   parameter int LINE_W       = 10,
   parameter int PER_W        = 8,
   parameter int BYTE_W       = 8,
   parameter int RUNIN_CYC    = 7,
   parameter int BIT_CLKS_DEF = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_start,
   input logic [LINE_W-1:0] line_num,
   input logic              field2,
   input logic              std_625,
   input logic [PER_W-1:0]  bit_clks,
   input logic              cc_level,
   input logic              cc_valid
);
   localparam int NSLOT = RUNIN_CYC + 3 + 2 * BYTE_W;

   logic [PER_W-1:0] p_exp;
   logic             ok_q;
   logic             aborted;
   logic [31:0]      run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_exp   <= PER_W'(BIT_CLKS_DEF);
         ok_q    <= 1'b0;
         aborted <= 1'b0;
         run     <= '0;
      end else begin
         if (line_start) begin
            p_exp <= (bit_clks == '0) ? PER_W'(BIT_CLKS_DEF) : bit_clks;
            ok_q  <= cc_ser_pkg::is_caption_line({{(32-LINE_W){1'b0}}, line_num},
                                                 field2, std_625);
         end
         if (line_start)     aborted <= 1'b1;
         else if (!cc_valid) aborted <= 1'b0;
         run <= cc_valid ? run + 1 : 32'd0;
      end
   end

   always @(negedge clk)
      if (!rst_n)
         assert_reset_quiet_R1: assert (!cc_valid && !cc_level);

   assert_level_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_valid |-> !cc_level);

   assert_only_caption_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cc_valid) && !$past(line_start)) |-> ok_q);

   assert_burst_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cc_valid) && !aborted && !$past(line_start)) |-> (run == NSLOT * p_exp));

   assert_runin_starts_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cc_valid) && !$past(line_start) && p_exp >= 2) |-> cc_level);
endmodule

bind cc_line_serializer cc_line_serializer_chk #(
   .LINE_W(LINE_W), .PER_W(PER_W), .BYTE_W(BYTE_W),
   .RUNIN_CYC(RUNIN_CYC), .BIT_CLKS_DEF(BIT_CLKS_DEF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
   .field2(field2), .std_625(std_625), .bit_clks(bit_clks),
   .cc_level(cc_level), .cc_valid(cc_valid));

// File: tb/cc_line_serializer_test.sv
module cc_line_serializer_test;
   localparam int SP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic [9:0] line_num = '0;
   logic       field2 = 1'b0;
   logic       std_625 = 1'b0;
   logic [10:0] pix_cnt = '0;
   logic [7:0] bit_clks = 8'd4;
   logic [7:0] f1_byte_a = '0, f1_byte_b = '0, f2_byte_a = '0, f2_byte_b = '0;
   logic       cc_level, cc_valid;

   int checks = 0;
   int fails  = 0;

   cc_line_serializer #(.START_PIX(SP)) uut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
      .field2(field2), .std_625(std_625), .pix_cnt(pix_cnt), .bit_clks(bit_clks),
      .f1_byte_a(f1_byte_a), .f1_byte_b(f1_byte_b), .f2_byte_a(f2_byte_a),
      .f2_byte_b(f2_byte_b), .cc_level(cc_level), .cc_valid(cc_valid));

   always #5 clk = ~clk;

   function automatic logic exp_level(int o, int p, logic [7:0] a, logic [7:0] b);
      int s = o / p;
      int c = o % p;
      if (s < 7)       return c < (p / 2);
      else if (s < 9)  return 1'b0;
      else if (s == 9) return 1'b1;
      else if (s < 18) return a[s-10];
      else             return b[s-18];
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One line: strobe, then count pixels and compare every cycle of the line.
   task automatic run_line(string req, int ln, bit f2, bit s625, logic [7:0] a,
                           logic [7:0] b, int clks, bit on, bit mid_write);
      int p = (clks == 0) ? 27 : clks;
      int n = SP + 26 * p + 6;
      int bad_v = -1, bad_l = -1;
      int av = 0, ev = 0, al = 0, el = 0;
      @(negedge clk);
      line_num = 10'(ln); field2 = f2; std_625 = s625; bit_clks = 8'(clks);
      if (f2) begin f2_byte_a = a; f2_byte_b = b; f1_byte_a = ~a; f1_byte_b = ~b; end
      else    begin f1_byte_a = a; f1_byte_b = b; f2_byte_a = ~a; f2_byte_b = ~b; end
      line_start = 1'b1; pix_cnt = '0;
      @(posedge clk); @(negedge clk);
      line_start = 1'b0; pix_cnt = 11'd1;
      for (int j = 1; j <= n; j++) begin
         @(posedge clk); @(negedge clk);
         begin
            logic xv, xl;
            xv = on && (j >= SP + 1) && (j <= SP + 26 * p);
            xl = xv ? exp_level(j - SP - 1, p, a, b) : 1'b0;
            if (bad_v < 0 && cc_valid !== xv) begin bad_v = j; av = cc_valid; ev = xv; end
            if (bad_l < 0 && cc_level !== xl) begin bad_l = j; al = cc_level; el = xl; end
         end
         pix_cnt = 11'(j + 1);
         if (mid_write && j == 3) begin
            f1_byte_a = 8'h00; f1_byte_b = 8'hFF; f2_byte_a = 8'h00; f2_byte_b = 8'hFF;
            bit_clks = 8'd9;
         end
      end
      check(req, $sformatf("valid window line %0d (first bad cycle %0d)", ln, bad_v), av, ev);
      check(req, $sformatf("level stream line %0d (first bad cycle %0d)", ln, bad_l), al, el);
      pix_cnt = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", cc_valid, 0);
      check("R1", "level in reset", cc_level, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "valid after reset", cc_valid, 0);
      check("R1", "level after reset", cc_level, 0);
   endtask

   task automatic t_field1();
      run_line("R2 R5 R6 R7 R8", 21, 1'b0, 1'b0, 8'hA5, 8'h3C, 4, 1'b1, 1'b0);
      run_line("R2 R5 R6 R7 R8", 22, 1'b0, 1'b1, 8'h81, 8'h7E, 5, 1'b1, 1'b0);
   endtask

   task automatic t_field2();
      run_line("R3 R5 R8", 284, 1'b1, 1'b0, 8'h12, 8'hC7, 4, 1'b1, 1'b0);
      run_line("R3 R5 R8", 335, 1'b1, 1'b1, 8'hF0, 8'h0B, 7, 1'b1, 1'b0);
   endtask

   task automatic t_other_lines();
      run_line("R4", 21, 1'b0, 1'b1, 8'hFF, 8'hFF, 4, 1'b0, 1'b0);
      run_line("R4", 22, 1'b0, 1'b0, 8'hFF, 8'hFF, 4, 1'b0, 1'b0);
      run_line("R4", 284, 1'b0, 1'b0, 8'hFF, 8'hFF, 4, 1'b0, 1'b0);
      run_line("R4", 21, 1'b1, 1'b0, 8'hFF, 8'hFF, 4, 1'b0, 1'b0);
      run_line("R4", 336, 1'b1, 1'b1, 8'hFF, 8'hFF, 4, 1'b0, 1'b0);
   endtask

   task automatic t_period();
      run_line("R9 R6", 21, 1'b0, 1'b0, 8'h5A, 8'h96, 0, 1'b1, 1'b0);
      run_line("R9 R6", 284, 1'b1, 1'b0, 8'h6D, 8'hB2, 2, 1'b1, 1'b0);
   endtask

   task automatic t_mid_write();
      run_line("R10", 22, 1'b0, 1'b1, 8'hC3, 8'h24, 5, 1'b1, 1'b1);
      run_line("R10", 335, 1'b1, 1'b1, 8'h9E, 8'h41, 3, 1'b1, 1'b1);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_field1();
      t_field2();
      t_other_lines();
      t_period();
      t_mid_write();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule